// File: doc/BRIEF.md
# Receive-Watermark Software and Hardware Flow Controller

This block paces one serial channel in both directions. It watches how full the local receive FIFO is. When the fill count reaches an upper mark, it asks the far end to stop. It does this by lowering permission on an active-low request-to-send output and, if software flow control is on, by placing a stop character into the outgoing stream. When the FIFO has drained to a lower mark, it sends a resume character and grants permission again. The two marks are separate, so the request does not toggle back and forth around one level.

In the other direction, the block looks at every character coming from the line. When software flow control is on, a stop or resume character is taken out of the stream and never reaches the receive FIFO. A stop character holds back local data, and a resume character releases it. The block also decides which byte the serializer loads next. A queued control character goes ahead of FIFO data, and a load happens only when the serializer reports that it is idle. A character that is already shifting out is never cut short. When hardware handshaking is on, a high clear-to-send input blocks every load.

The host programs both character codes and both fill marks. The serializer, the baud timing and the FIFO storage are outside this block.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: When not in the stopped state and `rxf_level >= cfg_stop_level`, the block enters the stopped state on the next clock. If `cfg_inband_en` is 1, it also queues the stop character `cfg_stop_char`.
- R2: In the stopped state, the block stays stopped while `rxf_level > cfg_go_level`. Once `rxf_level <= cfg_go_level`, it leaves the stopped state on the next clock. If `cfg_inband_en` is 1, it also queues the resume character `cfg_go_char`. Queuing one control character cancels the other.
- R3: A queued control character is offered before FIFO data. While it is loaded, `ser_data` carries the character code and `txf_pop` is 0. The queue entry clears on the clock where it is loaded.
- R4: `ser_load` is 1 only in a cycle where `ser_ready` is 1.
- R5: With `cfg_inband_en` = 1, a received `cfg_stop_char` blocks all data loads from the next clock onward. A received `cfg_go_char` lifts the block from the next clock onward. Control characters are still sent while data is blocked.
- R6: With `cfg_inband_en` = 1, a received character equal to either control code gives `rxf_wr_en` = 0 in that cycle. Any other received character is passed to `rxf_wr_data` with `rxf_wr_en` = 1 in the same cycle.
- R7: With `cfg_inband_en` = 0, every received character is written to the FIFO. Received characters cause no pause, and nothing is queued.
- R8: `rts_n` is 1 exactly when `cfg_hw_en` is 1 and the block is in the stopped state. Otherwise it is 0.
- R9: When `cfg_hw_en` is 1 and `cts_n` is 1, `ser_load` is 0. When `cfg_hw_en` is 0, `cts_n` has no effect.
- R10: After reset, the block is not stopped, nothing is queued and it is not paused. So `rts_n` = 0 and no control character is loaded.
- R11: `txf_pop` is 1 exactly when FIFO data is loaded. In that cycle `txf_empty` = 0 and `ser_data` equals `txf_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_inband_en | input | 1 | Enables software character flow control |
| cfg_hw_en | input | 1 | Enables RTS/CTS handshaking |
| cfg_go_char | input | DATA_W | Resume character code |
| cfg_stop_char | input | DATA_W | Stop character code |
| cfg_stop_level | input | LVL_W | Fill count at or above which the block stops |
| cfg_go_level | input | LVL_W | Fill count at or below which the block resumes |
| rxf_level | input | LVL_W | Current receive FIFO fill count, 0 to FIFO_DEPTH |
| rx_char_valid | input | 1 | A received character is present |
| rx_char | input | DATA_W | Received character |
| rxf_wr_en | output | 1 | Write strobe to the receive FIFO |
| rxf_wr_data | output | DATA_W | Data written to the receive FIFO |
| txf_empty | input | 1 | Transmit FIFO holds no data |
| txf_data | input | DATA_W | Head of the transmit FIFO |
| txf_pop | output | 1 | Removes the head of the transmit FIFO |
| ser_ready | input | 1 | Serializer is idle and can take a character |
| ser_load | output | 1 | Loads `ser_data` into the serializer |
| ser_data | output | DATA_W | Character for the serializer |
| cts_n | input | 1 | Clear to send from the far end, active low |
| rts_n | output | 1 | Request to send toward the far end, active low |

## Verification
The bench targets the hysteresis band. A fill count between the two marks must change neither `rts_n` nor the queue, so a design with a single threshold would drop `rts_n` or send a resume character too early. It also sets up a queued stop character at the same moment FIFO data is waiting. A design with the wrong priority would pop data first and leave the far end talking into a full buffer. Other tests check that control characters are held back from the receive FIFO and that a received stop character blocks local data. A design that gets these wrong would write the character into the FIFO or keep sending. With software mode off, the same characters must pass through untouched. Finally, the bench holds `cts_n` high, and also `ser_ready` low, while data is waiting. A design that ignores either one would load a character it must not load.

// File: rtl/xonxoff_flow_pkg.sv
package xonxoff_flow_pkg;
    typedef struct packed {
        logic stopped;
        logic pend_stop;
        logic pend_go;
        logic paused;
    } flow_state_t;
endpackage

// File: rtl/xonxoff_watermark.sv
module xonxoff_watermark #(
    parameter int LVL_W = 5
) (
    input  logic             stopped_q,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] stop_level,
    input  logic [LVL_W-1:0] go_level,
    output logic             stopped_d
);
    always_comb begin
        stopped_d = stopped_q;
        if (!stopped_q && (level >= stop_level)) begin
            stopped_d = 1'b1;
        end else if (stopped_q && (level <= go_level)) begin
            stopped_d = 1'b0;
        end
    end
endmodule

// File: rtl/xonxoff_rx_filter.sv
module xonxoff_rx_filter #(
    parameter int DATA_W = 8
) (
    input  logic              inband_en,
    input  logic [DATA_W-1:0] go_char,
    input  logic [DATA_W-1:0] stop_char,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_char,
    output logic              seen_go,
    output logic              seen_stop,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    always_comb begin
        seen_stop = inband_en && rx_valid && (rx_char == stop_char);
        seen_go   = inband_en && rx_valid && (rx_char == go_char) && !seen_stop;
        wr_en     = rx_valid && !(inband_en &&
                    ((rx_char == stop_char) || (rx_char == go_char)));
        wr_data   = rx_char;
    end
endmodule

// File: rtl/xonxoff_tx_arbiter.sv
module xonxoff_tx_arbiter #(
    parameter int DATA_W = 8
) (
    input  logic              ser_ready,
    input  logic              cts_block,
    input  logic              pend_stop,
    input  logic              pend_go,
    input  logic              paused,
    input  logic              txf_empty,
    input  logic [DATA_W-1:0] txf_data,
    input  logic [DATA_W-1:0] go_char,
    input  logic [DATA_W-1:0] stop_char,
    output logic              load,
    output logic [DATA_W-1:0] data,
    output logic              pop,
    output logic              sent_stop,
    output logic              sent_go
);
    logic slot;

    always_comb begin
        slot      = ser_ready && !cts_block;
        sent_stop = 1'b0;
        sent_go   = 1'b0;
        pop       = 1'b0;
        data      = txf_data;
        if (slot && pend_stop) begin
            sent_stop = 1'b1;
            data      = stop_char;
        end else if (slot && pend_go) begin
            sent_go = 1'b1;
            data    = go_char;
        end else if (slot && !paused && !txf_empty) begin
            pop = 1'b1;
        end
        load = sent_stop || sent_go || pop;
    end
endmodule

// File: rtl/xonxoff_flow_ctrl.sv
module xonxoff_flow_ctrl #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_inband_en,
    input  logic                              cfg_hw_en,
    input  logic [DATA_W-1:0]                 cfg_go_char,
    input  logic [DATA_W-1:0]                 cfg_stop_char,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]   cfg_stop_level,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]   cfg_go_level,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]   rxf_level,
    input  logic                              rx_char_valid,
    input  logic [DATA_W-1:0]                 rx_char,
    output logic                              rxf_wr_en,
    output logic [DATA_W-1:0]                 rxf_wr_data,
    input  logic                              txf_empty,
    input  logic [DATA_W-1:0]                 txf_data,
    output logic                              txf_pop,
    input  logic                              ser_ready,
    output logic                              ser_load,
    output logic [DATA_W-1:0]                 ser_data,
    input  logic                              cts_n,
    output logic                              rts_n
);
    import xonxoff_flow_pkg::*;

    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    flow_state_t st_q, st_d;
    logic        stopped_nx;
    logic        seen_go, seen_stop;
    logic        sent_go, sent_stop;

    xonxoff_watermark #(.LVL_W(LVL_W)) wm_i (
        .stopped_q  (st_q.stopped),
        .level      (rxf_level),
        .stop_level (cfg_stop_level),
        .go_level   (cfg_go_level),
        .stopped_d  (stopped_nx)
    );

    xonxoff_rx_filter #(.DATA_W(DATA_W)) rxf_i (
        .inband_en (cfg_inband_en),
        .go_char   (cfg_go_char),
        .stop_char (cfg_stop_char),
        .rx_valid  (rx_char_valid),
        .rx_char   (rx_char),
        .seen_go   (seen_go),
        .seen_stop (seen_stop),
        .wr_en     (rxf_wr_en),
        .wr_data   (rxf_wr_data)
    );

    xonxoff_tx_arbiter #(.DATA_W(DATA_W)) txa_i (
        .ser_ready (ser_ready),
        .cts_block (cfg_hw_en && cts_n),
        .pend_stop (st_q.pend_stop),
        .pend_go   (st_q.pend_go),
        .paused    (st_q.paused),
        .txf_empty (txf_empty),
        .txf_data  (txf_data),
        .go_char   (cfg_go_char),
        .stop_char (cfg_stop_char),
        .load      (ser_load),
        .data      (ser_data),
        .pop       (txf_pop),
        .sent_stop (sent_stop),
        .sent_go   (sent_go)
    );

    always_comb begin
        st_d         = st_q;
        st_d.stopped = stopped_nx;
        if (!cfg_inband_en) begin
            st_d.pend_stop = 1'b0;
            st_d.pend_go   = 1'b0;
            st_d.paused    = 1'b0;
        end else begin
            if (stopped_nx && !st_q.stopped) begin
                st_d.pend_stop = 1'b1;
                st_d.pend_go   = 1'b0;
            end else if (!stopped_nx && st_q.stopped) begin
                st_d.pend_go   = 1'b1;
                st_d.pend_stop = 1'b0;
            end else begin
                if (sent_stop) st_d.pend_stop = 1'b0;
                if (sent_go)   st_d.pend_go   = 1'b0;
            end
            if (seen_stop)    st_d.paused = 1'b1;
            else if (seen_go) st_d.paused = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rts_n = cfg_hw_en && st_q.stopped;
endmodule

// File: rtl/xonxoff_flow_chk.sv
module xonxoff_flow_chk #(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_inband_en,
    input logic              cfg_hw_en,
    input logic [DATA_W-1:0] cfg_go_char,
    input logic [DATA_W-1:0] cfg_stop_char,
    input logic [LVL_W-1:0]  cfg_stop_level,
    input logic [LVL_W-1:0]  cfg_go_level,
    input logic [LVL_W-1:0]  rxf_level,
    input logic              rx_char_valid,
    input logic [DATA_W-1:0] rx_char,
    input logic              rxf_wr_en,
    input logic [DATA_W-1:0] rxf_wr_data,
    input logic              txf_empty,
    input logic [DATA_W-1:0] txf_data,
    input logic              txf_pop,
    input logic              ser_ready,
    input logic              ser_load,
    input logic [DATA_W-1:0] ser_data,
    input logic              cts_n,
    input logic              rts_n
);
    // R4
    load_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> ser_ready);
    // R9
    cts_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hw_en && cts_n) |-> !ser_load);
    // R11
    pop_matches_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txf_pop |-> (ser_load && !txf_empty && ser_data == txf_data));
    // R6
    ctrl_char_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_inband_en && rx_char_valid &&
         (rx_char == cfg_go_char || rx_char == cfg_stop_char)) |-> !rxf_wr_en);
    // R7
    passthru_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_inband_en && rx_char_valid) |-> (rxf_wr_en && rxf_wr_data == rx_char));
    // R8
    rts_idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_hw_en |-> !rts_n);
    // R1
    stop_needs_high_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hw_en && $past(cfg_hw_en) && $rose(rts_n)) |->
            $past(rxf_level >= cfg_stop_level));
    // R2
    go_needs_low_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hw_en && $past(cfg_hw_en) && $fell(rts_n)) |->
            $past(rxf_level <= cfg_go_level));
endmodule

bind xonxoff_flow_ctrl xonxoff_flow_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/xonxoff_flow_ctrl_tb_top.sv
module xonxoff_flow_ctrl_tb_top;
    localparam int DW = 8;
    localparam int LW = 5;
    localparam logic [7:0] GO = 8'h11;
    localparam logic [7:0] STOP = 8'h13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_inband_en = 1'b1, cfg_hw_en = 1'b1;
    logic [DW-1:0] cfg_go_char = GO, cfg_stop_char = STOP;
    logic [LW-1:0] cfg_stop_level = 5'd12, cfg_go_level = 5'd4, rxf_level = '0;
    logic rx_char_valid = 1'b0;
    logic [DW-1:0] rx_char = '0;
    logic rxf_wr_en;
    logic [DW-1:0] rxf_wr_data;
    logic txf_empty = 1'b1;
    logic [DW-1:0] txf_data = 8'h41;
    logic txf_pop;
    logic ser_ready = 1'b0;
    logic ser_load;
    logic [DW-1:0] ser_data;
    logic cts_n = 1'b0;
    logic rts_n;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    xonxoff_flow_ctrl dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg_inband_en = 1'b1; cfg_hw_en = 1'b1;
        rxf_level = '0; rx_char_valid = 1'b0; txf_empty = 1'b1;
        ser_ready = 1'b0; cts_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        ser_ready = 1'b1; #1;
        check("R10 rts_n", rts_n, 0);
        check("R10 ser_load", ser_load, 0);
    endtask

    task automatic t_watermark();
        do_reset();
        txf_empty = 1'b0;
        rxf_level = 5'd11; step();
        check("R1 below mark rts_n", rts_n, 0);
        rxf_level = 5'd12; step();
        check("R8 rts_n stopped", rts_n, 1);
        ser_ready = 1'b1; #1;
        check("R3 ctrl load", ser_load, 1);
        check("R1 stop char", ser_data, STOP);
        check("R3 no pop", txf_pop, 0);
        step();
        check("R11 data pop", txf_pop, 1);
        check("R11 data value", ser_data, 8'h41);
        ser_ready = 1'b0;
        rxf_level = 5'd8; step();
        check("R2 band holds rts_n", rts_n, 1);
        txf_empty = 1'b1; ser_ready = 1'b1; #1;
        check("R2 band queues nothing", ser_load, 0);
        ser_ready = 1'b0;
        rxf_level = 5'd4; step();
        check("R2 rts_n released", rts_n, 0);
        ser_ready = 1'b1; #1;
        check("R2 go load", ser_load, 1);
        check("R2 go char", ser_data, GO);
        step();
        check("R3 queue cleared", ser_load, 0);
    endtask

    task automatic t_remote();
        do_reset();
        rx_char_valid = 1'b1; rx_char = STOP; #1;
        check("R6 stop dropped", rxf_wr_en, 0);
        step();
        rx_char_valid = 1'b0; txf_empty = 1'b0; ser_ready = 1'b1; #1;
        check("R5 paused", ser_load, 0);
        rx_char_valid = 1'b1; rx_char = 8'h55; #1;
        check("R6 normal write", rxf_wr_en, 1);
        check("R6 normal data", rxf_wr_data, 8'h55);
        rx_char = GO; #1;
        check("R6 go dropped", rxf_wr_en, 0);
        step();
        rx_char_valid = 1'b0; #1;
        check("R5 resumed", txf_pop, 1);
    endtask

    task automatic t_inband_off();
        do_reset();
        cfg_inband_en = 1'b0;
        rx_char_valid = 1'b1; rx_char = STOP; #1;
        check("R7 passthru", rxf_wr_en, 1);
        step();
        rx_char_valid = 1'b0; txf_empty = 1'b0; ser_ready = 1'b1; #1;
        check("R7 no pause", txf_pop, 1);
        txf_empty = 1'b1; ser_ready = 1'b0; rxf_level = 5'd16; step();
        ser_ready = 1'b1; #1;
        check("R7 nothing queued", ser_load, 0);
    endtask

    task automatic t_cts();
        do_reset();
        txf_empty = 1'b0; cts_n = 1'b1; ser_ready = 1'b1; #1;
        check("R9 cts blocks", ser_load, 0);
        cfg_hw_en = 1'b0; #1;
        check("R9 cts ignored", ser_load, 1);
        cfg_hw_en = 1'b1; cts_n = 1'b0; #1;
        check("R9 cts granted", ser_load, 1);
        ser_ready = 1'b0; #1;
        check("R4 wait for ready", ser_load, 0);
        check("R4 no pop", txf_pop, 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_watermark();
        t_remote();
        t_inband_off();
        t_cts();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule